// File: doc/BRIEF.md
# Rotating Operand Broadcast Ring

This block sits between a register file with a small number of read ports and a larger set of function units that each need several source operands. It gathers the registers still awaited by the units and fetches them through the read ports. Each fetched value goes into a ring slot together with a one-hot tag that names its register. The ring turns one position every running clock. Every position drives a broadcast bus, and each unit's operand input k listens only to bus k. A unit whose requested register appears on its operand's bus receives a go-read strobe. Any number of units may capture the same broadcast in the same cycle.

A value stays in the ring for as long as any unit still requests its register. Once every request for it has dropped, its slot empties at the next running edge and may be refilled in that same edge. On a refill, the register requested on operand k is preferred for position k, so a lone request is served without any rotation. Remaining free positions take the lowest-numbered outstanding register. A run/hold input freezes the whole ring without losing any entry. A forwarding input takes a result from a write path straight into the head position, so readers can pick it up before it reaches the register file.

Top module: `hopper_ring`

## Requirements
- R1: While `rst` is high at a clock edge, every slot is emptied: `bus_vld` is 0 and `bus_tag` is 0 at every position. With no request present, `go_rd` and `rf_rsel` are 0.
- R2: On a running clock (`run`=1), a slot at position q whose register is still requested moves to position (q+1) mod NSLOT with its tag and data unchanged. The last position wraps to position 0.
- R3: A slot whose register is no longer requested by any unit (bit index r of `fu_req` word f*NSLOT+k) leaves the ring at the next running edge. Once all requests have dropped, the ring is empty.
- R4: Each cycle, every free position issues at most one one-hot register select on its own read port `rf_rsel[p]`. The returned `rf_rdata[p]` is stored in position p with that tag. Nothing is selected when nothing is requested.
- R5: A register is never held in two slots at once, and is never fetched while it is already in the ring.
- R6: A free position k first takes the lowest-numbered outstanding register that some unit requests on operand k. Such a value is broadcast on bus k in the cycle after the fetch.
- R7: Positions still free after R6 take the remaining outstanding registers in ascending register number, filling positions in ascending order.
- R8: `go_rd[f*NSLOT+k]` is high exactly when the ring runs and bus k is valid with a tag that matches unit f's operand-k request. Each request sees exactly one strobe, with the correct data. Several units may be strobed in one cycle.
- R9: An empty position drives an all-zero tag and therefore never matches.
- R10: While `run`=0, slot contents, tags and validity are held unchanged, `go_rd`, `rf_rsel` and `fwd_rdy` are 0, and no entry is lost on resume.
- R11: `fwd_rdy` is high when the ring runs and position 0 will be free after rotation. A forwarded value whose register is outstanding and not already in the ring is loaded into position 0 ahead of any fetch for that position. One that no unit requests is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Ring advance enable; low holds every slot |
| fu_req | input | NFU*NSLOT*NREG | One-hot register request per unit f and operand k, word f*NSLOT+k |
| rf_rsel | output | NSLOT*NREG | One-hot register select per read port |
| rf_rdata | input | NSLOT*DW | Read data returned by the register file in the same cycle |
| fwd_vld | input | 1 | Forwarded result offered |
| fwd_tag | input | NREG | One-hot register of the forwarded result |
| fwd_data | input | DW | Forwarded result value |
| fwd_rdy | output | 1 | Head position can take a forwarded result |
| bus_vld | output | NSLOT | Broadcast bus k carries a value |
| bus_tag | output | NSLOT*NREG | One-hot tag on each broadcast bus |
| bus_data | output | NSLOT*DW | Data on each broadcast bus |
| go_rd | output | NFU*NSLOT | Go-read strobe per unit and operand |

## Verification
The bench targets four corner cases. The first is one register wanted by several operands at once, which must be fetched only once and rotate past every listening position. A design that refetches would show duplicate tags on the buses, and one that evicts early would leave a request unserved. The second is more outstanding registers than free positions: the first fetch must follow the operand preference and then ascending order, and a wrong priority chain shows up as wrong select vectors. The third is a pause with a full ring, where any slip, eviction or strobe while held would break the frozen bus state or lose a later delivery. The fourth is forwarding, where the value must arrive from the forward path rather than the register file, and an unrequested forward must leave the ring empty.

// File: rtl/hop_pkg.sv
`timescale 1ns/1ps
package hop_pkg;
  localparam int HOP_NSLOT = 4;
  localparam int HOP_NREG  = 32;
  localparam int HOP_DW    = 32;
  localparam int HOP_NFU   = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_KEEP = 2'd1,
    SRC_FWD  = 2'd2,
    SRC_RF   = 2'd3
  } hop_src_e;
endpackage

// File: rtl/hop_lsb.sv
`timescale 1ns/1ps
// Isolates the lowest set bit of a request vector when enabled.
module hop_lsb #(
  parameter int W = 32
) (
  input  logic [W-1:0] req,
  input  logic         en,
  output logic [W-1:0] gnt
);
  assign gnt = en ? (req & (~req + W'(1))) : '0;
endmodule

// File: rtl/hop_fill.sv
`timescale 1ns/1ps
// Refill chooser: pass one gives each free position its own operand's
// lowest outstanding register, pass two hands out the remainder in
// ascending order. Masks are chained so no register is picked twice.
module hop_fill #(
  parameter int NSLOT = 4,
  parameter int NREG  = 32
) (
  input  logic [NSLOT-1:0]      slot_free,
  input  logic [NSLOT*NREG-1:0] op_pend,
  input  logic [NREG-1:0]       avail,
  output logic [NSLOT*NREG-1:0] pick
);
  logic [NREG-1:0] m_own [NSLOT+1];
  logic [NREG-1:0] m_any [NSLOT+1];
  logic [NREG-1:0] g_own [NSLOT];
  logic [NREG-1:0] g_any [NSLOT];

  assign m_own[0] = avail;
  assign m_any[0] = m_own[NSLOT];

  for (genvar p = 0; p < NSLOT; p++) begin : g_pos
    hop_lsb #(.W(NREG)) u_own (
      .req (op_pend[p*NREG +: NREG] & m_own[p]),
      .en  (slot_free[p]),
      .gnt (g_own[p])
    );
    assign m_own[p+1] = m_own[p] & ~g_own[p];

    hop_lsb #(.W(NREG)) u_any (
      .req (m_any[p]),
      .en  (slot_free[p] && (g_own[p] == '0)),
      .gnt (g_any[p])
    );
    assign m_any[p+1] = m_any[p] & ~g_any[p];

    assign pick[p*NREG +: NREG] = g_own[p] | g_any[p];
  end
endmodule

// File: rtl/hop_match.sv
`timescale 1ns/1ps
// Tag comparison: operand k of every unit watches broadcast bus k only.
module hop_match #(
  parameter int NSLOT = 4,
  parameter int NREG  = 32,
  parameter int NFU   = 4
) (
  input  logic                      run,
  input  logic [NSLOT-1:0]          bus_vld,
  input  logic [NSLOT*NREG-1:0]     bus_tag,
  input  logic [NFU*NSLOT*NREG-1:0] fu_req,
  output logic [NFU*NSLOT-1:0]      go_rd
);
  for (genvar f = 0; f < NFU; f++) begin : g_fu
    for (genvar k = 0; k < NSLOT; k++) begin : g_op
      localparam int I = f*NSLOT + k;
      assign go_rd[I] = run & bus_vld[k] &
                        (|(bus_tag[k*NREG +: NREG] & fu_req[I*NREG +: NREG]));
    end
  end
endmodule

// File: rtl/hopper_ring.sv
`timescale 1ns/1ps
module hopper_ring import hop_pkg::*; #(
  parameter int NSLOT = HOP_NSLOT,
  parameter int NREG  = HOP_NREG,
  parameter int DW    = HOP_DW,
  parameter int NFU   = HOP_NFU
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic [NFU*NSLOT*NREG-1:0] fu_req,
  output logic [NSLOT*NREG-1:0]     rf_rsel,
  input  logic [NSLOT*DW-1:0]       rf_rdata,
  input  logic                      fwd_vld,
  input  logic [NREG-1:0]           fwd_tag,
  input  logic [DW-1:0]             fwd_data,
  output logic                      fwd_rdy,
  output logic [NSLOT-1:0]          bus_vld,
  output logic [NSLOT*NREG-1:0]     bus_tag,
  output logic [NSLOT*DW-1:0]       bus_data,
  output logic [NFU*NSLOT-1:0]      go_rd
);
  // Slot state, one register set per ring position
  logic            s_vld [NSLOT];
  logic [NREG-1:0] s_tag [NSLOT];
  logic [DW-1:0]   s_dat [NSLOT];

  logic [NSLOT*NREG-1:0] op_pend;
  logic [NREG-1:0]       pend;
  logic [NREG-1:0]       occ_or;
  logic [NSLOT-1:0]      kept;
  logic [NSLOT-1:0]      keep_new;
  logic [NSLOT-1:0]      slot_free;
  logic [NREG-1:0]       fwd_mask;
  logic [NREG-1:0]       avail;
  logic [NSLOT*NREG-1:0] pick;
  logic                  fwd_load;
  hop_src_e              src [NSLOT];

  // Outstanding registers per operand and overall
  always_comb begin
    op_pend = '0;
    pend    = '0;
    for (int k = 0; k < NSLOT; k++) begin
      for (int f = 0; f < NFU; f++) begin
        op_pend[k*NREG +: NREG] = op_pend[k*NREG +: NREG] |
                                  fu_req[(f*NSLOT+k)*NREG +: NREG];
      end
      pend = pend | op_pend[k*NREG +: NREG];
    end
  end

  // Registers already resident (empty slots carry a zero tag)
  always_comb begin
    occ_or = '0;
    for (int q = 0; q < NSLOT; q++) occ_or = occ_or | s_tag[q];
  end

  for (genvar q = 0; q < NSLOT; q++) begin : g_kept
    assign kept[q] = s_vld[q] & (|(s_tag[q] & pend));
  end

  for (genvar p = 0; p < NSLOT; p++) begin : g_keep
    localparam int Q = (p + NSLOT - 1) % NSLOT;
    assign keep_new[p] = kept[Q];
  end

  assign fwd_rdy  = run & ~keep_new[0];
  assign fwd_load = fwd_vld & fwd_rdy & (|(fwd_tag & pend & ~occ_or));
  assign fwd_mask = fwd_load ? fwd_tag : '0;
  assign avail    = pend & ~occ_or & ~fwd_mask;

  for (genvar p = 0; p < NSLOT; p++) begin : g_free
    if (p == 0) begin : g_head
      assign slot_free[p] = run & ~keep_new[p] & ~fwd_load;
    end else begin : g_body
      assign slot_free[p] = run & ~keep_new[p];
    end
  end

  hop_fill #(.NSLOT(NSLOT), .NREG(NREG)) u_fill (
    .slot_free (slot_free),
    .op_pend   (op_pend),
    .avail     (avail),
    .pick      (pick)
  );

  assign rf_rsel = pick;

  // Per-position next-state source and slot registers
  for (genvar p = 0; p < NSLOT; p++) begin : g_slot
    localparam int Q = (p + NSLOT - 1) % NSLOT;

    always_comb begin
      if (keep_new[p])                     src[p] = SRC_KEEP;
      else if ((p == 0) && fwd_load)       src[p] = SRC_FWD;
      else if (|pick[p*NREG +: NREG])      src[p] = SRC_RF;
      else                                 src[p] = SRC_NONE;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s_vld[p] <= 1'b0;
        s_tag[p] <= '0;
        s_dat[p] <= '0;
      end else if (run) begin
        case (src[p])
          SRC_KEEP: begin
            s_vld[p] <= 1'b1;
            s_tag[p] <= s_tag[Q];
            s_dat[p] <= s_dat[Q];
          end
          SRC_FWD: begin
            s_vld[p] <= 1'b1;
            s_tag[p] <= fwd_tag;
            s_dat[p] <= fwd_data;
          end
          SRC_RF: begin
            s_vld[p] <= 1'b1;
            s_tag[p] <= pick[p*NREG +: NREG];
            s_dat[p] <= rf_rdata[p*DW +: DW];
          end
          default: begin
            s_vld[p] <= 1'b0;
            s_tag[p] <= '0;
            s_dat[p] <= '0;
          end
        endcase
      end
    end

    assign bus_vld[p]              = s_vld[p];
    assign bus_tag[p*NREG +: NREG] = s_tag[p];
    assign bus_data[p*DW +: DW]    = s_dat[p];
  end

  hop_match #(.NSLOT(NSLOT), .NREG(NREG), .NFU(NFU)) u_match (
    .run     (run),
    .bus_vld (bus_vld),
    .bus_tag (bus_tag),
    .fu_req  (fu_req),
    .go_rd   (go_rd)
  );
endmodule

// File: rtl/hopper_ring_chk.sv
`timescale 1ns/1ps
module hopper_ring_chk #(
  parameter int NSLOT = 4,
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int NFU   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      run,
  input logic [NFU*NSLOT*NREG-1:0] fu_req,
  input logic [NSLOT*NREG-1:0]     rf_rsel,
  input logic                      fwd_rdy,
  input logic [NSLOT-1:0]          bus_vld,
  input logic [NSLOT*NREG-1:0]     bus_tag,
  input logic [NSLOT*DW-1:0]       bus_data,
  input logic [NFU*NSLOT-1:0]      go_rd
);
  logic [NREG-1:0]  want;
  logic [NSLOT-1:0] col [NREG];

  always_comb begin
    want = '0;
    for (int i = 0; i < NFU*NSLOT; i++) want = want | fu_req[i*NREG +: NREG];
  end

  always_comb begin
    for (int r = 0; r < NREG; r++)
      for (int p = 0; p < NSLOT; p++)
        col[r][p] = bus_vld[p] & bus_tag[p*NREG + r];
  end

  for (genvar p = 0; p < NSLOT; p++) begin : g_pos
    localparam int Q = (p + NSLOT - 1) % NSLOT;

    assert_rotate_R2: assert property (@(posedge clk) disable iff (rst)
      (run && bus_vld[Q] && (|(bus_tag[Q*NREG +: NREG] & want))) |=>
      (bus_vld[p] && bus_tag[p*NREG +: NREG] == $past(bus_tag[Q*NREG +: NREG]) &&
       bus_data[p*DW +: DW] == $past(bus_data[Q*DW +: DW])));

    assert_evict_R3: assert property (@(posedge clk) disable iff (rst)
      (run && bus_vld[Q] && !(|(bus_tag[Q*NREG +: NREG] & want))) |=>
      (bus_tag[p*NREG +: NREG] != $past(bus_tag[Q*NREG +: NREG])));

    assert_rsel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rf_rsel[p*NREG +: NREG]));

    assert_empty_zero_tag_R9: assert property (@(posedge clk) disable iff (rst)
      !bus_vld[p] |-> (bus_tag[p*NREG +: NREG] == '0));
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assert_single_copy_R5: assert property (@(posedge clk) disable iff (rst)
      $countones(col[r]) <= 1);
  end

  assert_hold_state_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(bus_vld) && $stable(bus_tag) && $stable(bus_data)));

  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !run |-> (go_rd == '0 && rf_rsel == '0 && !fwd_rdy));
endmodule

bind hopper_ring hopper_ring_chk #(
  .NSLOT(NSLOT), .NREG(NREG), .DW(DW), .NFU(NFU)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .fu_req(fu_req), .rf_rsel(rf_rsel),
  .fwd_rdy(fwd_rdy), .bus_vld(bus_vld), .bus_tag(bus_tag),
  .bus_data(bus_data), .go_rd(go_rd)
);

// File: tb/hopper_ring_tb.sv
`timescale 1ns/1ps
module hopper_ring_tb;
  localparam int NS = 4;
  localparam int NR = 32;
  localparam int DW = 32;
  localparam int NF = 4;

  // Vector: [43:40] cycle budget, then four requests of 10 bits:
  // {valid, unit[1:0], operand[1:0], register[4:0]}
  localparam logic [43:0] VEC [6] = '{
    {4'd1, 1'b1,2'd3,2'd3,5'd31, 1'b1,2'd2,2'd2,5'd17, 1'b1,2'd1,2'd1,5'd9,  1'b1,2'd0,2'd0,5'd4},
    {4'd1, 1'b0,2'd0,2'd0,5'd0,  1'b1,2'd2,2'd2,5'd6,  1'b1,2'd1,2'd2,5'd6,  1'b1,2'd0,2'd2,5'd6},
    {4'd4, 1'b1,2'd3,2'd0,5'd3,  1'b1,2'd2,2'd0,5'd2,  1'b1,2'd1,2'd0,5'd1,  1'b1,2'd0,2'd0,5'd0},
    {4'd3, 1'b1,2'd3,2'd0,5'd12, 1'b1,2'd2,2'd3,5'd10, 1'b1,2'd1,2'd1,5'd10, 1'b1,2'd0,2'd1,5'd12},
    {4'd1, 1'b1,2'd0,2'd0,5'd30, 1'b1,2'd1,2'd1,5'd3,  1'b1,2'd2,2'd2,5'd2,  1'b1,2'd3,2'd3,5'd1},
    {4'd4, 1'b1,2'd3,2'd2,5'd8,  1'b1,2'd2,2'd1,5'd8,  1'b1,2'd1,2'd0,5'd8,  1'b1,2'd0,2'd3,5'd8}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               run = 1'b1;
  logic [NF*NS*NR-1:0] fu_req = '0;
  logic [NS*NR-1:0]   rf_rsel;
  logic [NS*DW-1:0]   rf_rdata;
  logic               fwd_vld = 1'b0;
  logic [NR-1:0]      fwd_tag = '0;
  logic [DW-1:0]      fwd_data = '0;
  logic               fwd_rdy;
  logic [NS-1:0]      bus_vld;
  logic [NS*NR-1:0]   bus_tag;
  logic [NS*DW-1:0]   bus_data;
  logic [NF*NS-1:0]   go_rd;

  int checks = 0;
  int errors = 0;
  int req_reg [NF][NS];
  int pulses  [NF][NS];
  bit used    [NF][NS];
  logic [DW-1:0] exp_val [NR];

  always #10 clk = ~clk;

  hopper_ring u_dut (
    .clk(clk), .rst(rst), .run(run), .fu_req(fu_req), .rf_rsel(rf_rsel),
    .rf_rdata(rf_rdata), .fwd_vld(fwd_vld), .fwd_tag(fwd_tag),
    .fwd_data(fwd_data), .fwd_rdy(fwd_rdy), .bus_vld(bus_vld),
    .bus_tag(bus_tag), .bus_data(bus_data), .go_rd(go_rd)
  );

  function automatic logic [DW-1:0] regval(int r);
    return 32'h5A00_0000 + 32'(r) * 32'h0001_0101;
  endfunction

  // Register file model with combinational read
  always_comb begin
    rf_rdata = '0;
    for (int p = 0; p < NS; p++)
      for (int r = 0; r < NR; r++)
        if (rf_rsel[p*NR + r]) rf_rdata[p*DW +: DW] = rf_rdata[p*DW +: DW] | regval(r);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int f, input int k, input int r);
    fu_req[(f*NS+k)*NR + r] = 1'b1;
    req_reg[f][k] = r;
    pulses[f][k]  = 0;
    used[f][k]    = 1'b1;
  endtask

  function automatic int outstanding();
    int n = 0;
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < NS; k++)
        if (req_reg[f][k] >= 0) n++;
    return n;
  endfunction

  // Sample at the falling edge; a unit that sees its strobe takes the
  // data and drops its request.
  task automatic tick();
    bit dup;
    @(negedge clk);
    dup = 1'b0;
    for (int p = 0; p < NS; p++)
      for (int q = p + 1; q < NS; q++)
        if (bus_vld[p] && bus_vld[q] && bus_tag[p*NR +: NR] == bus_tag[q*NR +: NR]) dup = 1'b1;
    chk(!dup, "R5 no register in two slots", 64'(dup), 64'd0);
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < NS; k++)
        if (go_rd[f*NS+k]) begin
          pulses[f][k]++;
          if (req_reg[f][k] >= 0)
            chk(bus_data[k*DW +: DW] == exp_val[req_reg[f][k]], "R8 go-read data",
                64'(bus_data[k*DW +: DW]), 64'(exp_val[req_reg[f][k]]));
          fu_req[(f*NS+k)*NR +: NR] = '0;
          req_reg[f][k] = -1;
        end
  endtask

  task automatic drain(input int budget, input string tag);
    int n = 0;
    while (outstanding() > 0 && n < budget) begin
      tick();
      n++;
    end
    chk(outstanding() == 0, {tag, " all delivered in budget"}, 64'(outstanding()), 64'd0);
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < NS; k++)
        if (used[f][k]) begin
          chk(pulses[f][k] == 1, "R8 exactly one strobe per request", 64'(pulses[f][k]), 64'd1);
          used[f][k] = 1'b0;
        end
    tick();
    chk(bus_vld == '0, "R3 ring empties after requests drop", 64'(bus_vld), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [NS*NR-1:0] snap;
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < NS; k++) begin
        req_reg[f][k] = -1;
        pulses[f][k]  = 0;
        used[f][k]    = 1'b0;
      end
    for (int r = 0; r < NR; r++) exp_val[r] = regval(r);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(bus_vld == '0, "R1 reset empties slots", 64'(bus_vld), 64'd0);
    chk(bus_tag == '0, "R1 R9 reset tags zero", 64'(bus_tag[63:0]), 64'd0);
    chk(go_rd == '0, "R1 no strobe in reset", 64'(go_rd), 64'd0);
    rst = 1'b0;
    tick();
    chk(rf_rsel == '0, "R4 nothing requested nothing fetched", 64'(rf_rsel[63:0]), 64'd0);
    chk(fwd_rdy == 1'b1, "R11 empty head accepts forward", 64'(fwd_rdy), 64'd1);

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < 4; i++)
        if (VEC[v][i*10+9])
          set_req(int'(VEC[v][i*10+7 +: 2]), int'(VEC[v][i*10+5 +: 2]), int'(VEC[v][i*10 +: 5]));
      drain(int'(VEC[v][43:40]), $sformatf("R6 R8 vector %0d", v));
    end

    // R6 and R7: more outstanding registers than positions
    set_req(0, 0, 20); set_req(1, 0, 3); set_req(2, 0, 7); set_req(3, 0, 12);
    set_req(0, 1, 5);  set_req(1, 1, 1);
    #1;
    chk(rf_rsel[0*NR +: NR] == 32'(1) << 3, "R6 position 0 takes own operand", 64'(rf_rsel[0*NR +: NR]), 64'(32'(1) << 3));
    chk(rf_rsel[1*NR +: NR] == 32'(1) << 1, "R6 position 1 takes own operand", 64'(rf_rsel[1*NR +: NR]), 64'(32'(1) << 1));
    chk(rf_rsel[2*NR +: NR] == 32'(1) << 5, "R7 lowest remaining first", 64'(rf_rsel[2*NR +: NR]), 64'(32'(1) << 5));
    chk(rf_rsel[3*NR +: NR] == 32'(1) << 7, "R7 next lowest remaining", 64'(rf_rsel[3*NR +: NR]), 64'(32'(1) << 7));
    tick();
    tick();
    chk(bus_tag[0*NR +: NR] == 32'(1) << 7, "R2 wrap from last to first", 64'(bus_tag[0*NR +: NR]), 64'(32'(1) << 7));
    chk(bus_tag[3*NR +: NR] == 32'(1) << 5, "R2 shift by one position", 64'(bus_tag[3*NR +: NR]), 64'(32'(1) << 5));
    chk(bus_tag[1*NR +: NR] == 32'(1) << 12, "R7 refill after eviction", 64'(bus_tag[1*NR +: NR]), 64'(32'(1) << 12));
    drain(12, "R7 overflow set");

    // R10: pause with a full ring
    set_req(0, 0, 0); set_req(1, 0, 1); set_req(2, 0, 2); set_req(3, 0, 3);
    tick();
    chk(pulses[0][0] == 1, "R10 delivery before pause", 64'(pulses[0][0]), 64'd1);
    snap = bus_tag;
    run = 1'b0;
    for (int c = 0; c < 3; c++) begin
      tick();
      chk(go_rd == '0, "R10 no strobe while held", 64'(go_rd), 64'd0);
      chk(bus_tag == snap, "R10 tags frozen", 64'(bus_tag[63:0]), 64'(snap[63:0]));
      chk(bus_vld == '1, "R10 no slot lost", 64'(bus_vld), 64'hF);
      chk(rf_rsel == '0 && !fwd_rdy, "R10 no fetch or forward while held", 64'(fwd_rdy), 64'd0);
    end
    run = 1'b1;
    drain(6, "R10 resume");

    // R11: forwarded value takes the head position
    set_req(0, 0, 9);
    fwd_vld  = 1'b1;
    fwd_tag  = 32'(1) << 9;
    fwd_data = 32'hF0F0_0009;
    exp_val[9] = 32'hF0F0_0009;
    #1;
    chk(fwd_rdy == 1'b1, "R11 ready with free head", 64'(fwd_rdy), 64'd1);
    chk(rf_rsel == '0, "R11 forward replaces fetch", 64'(rf_rsel[63:0]), 64'd0);
    @(posedge clk);
    #1 fwd_vld = 1'b0;
    drain(1, "R11 forwarded data");
    exp_val[9] = regval(9);

    // R11: forward nobody asked for is dropped
    fwd_vld = 1'b1;
    fwd_tag = 32'(1) << 11;
    @(posedge clk);
    #1 fwd_vld = 1'b0;
    tick();
    chk(bus_vld == '0, "R11 unrequested forward dropped", 64'(bus_vld), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule